// File: doc/BRIEF.md
# Shadow-Register Interrupt Controller

This block runs interrupt handling for a small 32-bit core that has no privileged control registers. It watches up to 32 interrupt lines and two synchronous exception flags from the core. When an enabled interrupt is pending and the core is not already in a handler, the block saves the interrupted PC and the set of interrupts being serviced into private shadow registers. It then sends the core to a fixed handler vector and blocks further entries until the handler returns.

The core passes every custom-0 instruction (major opcode `0001011`) to the block, together with the value of its first source register. The block executes the instruction and answers with a register-file write, a PC redirect, a request to sleep until an interrupt arrives, or a load value for the countdown timer. The timer itself sits outside and drives interrupt line 0. An exception that cannot be serviced, because the handler is already running or that exception source is disabled, stops the core through a sticky halt flag.

Top module: `irq_shadow_ctrl`

## Requirements
- R1: After reset, all outputs are low. Every interrupt starts disabled: the disable mask is all ones, and the first mask-swap instruction reads back 0xFFFFFFFF.
- R2: The mask-swap instruction (funct7 3) loads rs1 into the disable mask and writes the previous mask to rd (instr[11:7]). When rd is 0, no register-file write happens.
- R3: A rising edge on a line marks that line pending. With LATCHED=1 the pending bit stays set after the line falls. With LATCHED=0 the pending bit clears when the line falls.
- R4: While no handler runs, a nonzero serviceable set (pending AND NOT mask) causes entry at the next clock edge. Entry redirects to VECTOR (default 0x10), stores the input PC in Q0 and the serviceable set in Q1, and removes those bits from pending.
- R5: While a handler runs, no further entry occurs and no redirect happens except through return.
- R6: The return instruction (funct7 2) redirects to Q0 and ends the handler. It also re-marks as pending every line still held high, so a held line enters again one cycle later.
- R7: Read-shadow (funct7 0) writes Q[instr[16:15]] to rd, with no write when rd is 0. Write-shadow (funct7 1) stores rs1 into Q[instr[8:7]].
- R8: Wait (funct7 4) raises the wait request, which stays high until the entry that services an interrupt.
- R9: Timer (funct7 5) pulses the timer load output with rs1 as the value, and writes the current timer count to rd.
- R10: If exception source 1 or 2 is pending while a handler runs, or while that source is disabled, halt rises one cycle later and stays high. No entry follows, and later instructions are ignored.
- R11: The illegal/ebreak/ecall flag sets pending bit 1, and the misaligned-access flag sets pending bit 2. An enabled exception outside a handler enters like any interrupt.
- R12: Words with a funct7 above 5, or with a major opcode other than 0001011, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_IRQ | Interrupt lines, line 0 from the timer |
| exc_instr_i | input | 1 | Illegal instruction, ebreak or ecall this cycle |
| exc_align_i | input | 1 | Misaligned load or store this cycle |
| pc_i | input | XLEN | PC of the current instruction |
| ci_valid_i | input | 1 | Custom instruction issued |
| ci_instr_i | input | 32 | Custom instruction word |
| ci_rs1_i | input | XLEN | rs1 value |
| tmr_count_i | input | XLEN | Current timer count |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | XLEN | Write data |
| redir_valid_o | output | 1 | PC redirect strobe |
| redir_pc_o | output | XLEN | Redirect target |
| wfi_req_o | output | 1 | Sleep until interrupt |
| halt_o | output | 1 | Fatal halt, sticky |
| tmr_load_o | output | 1 | Timer load strobe |
| tmr_value_o | output | XLEN | Timer load value |

## Verification
The hardest state to reach is a handler return while a line is still held high and a second line has become pending during the handler. That return must redirect to the saved PC, and the very next edge must enter again with both lines in Q1. The bench raises one line, enters, then raises a second line inside the handler and keeps both high across the return. It checks the two back-to-back redirects on consecutive cycles and reads Q1 afterwards. The halt inside a handler needs an exception-driven entry first: the bench enables source 2, enters through a misaligned flag, then raises the same flag again.

// File: rtl/irq_shadow_pkg.sv
package irq_shadow_pkg;
  localparam logic [6:0] CUSTOM0_OPC = 7'b0001011;

  typedef enum logic [6:0] {
    F7_GETQ    = 7'd0,
    F7_SETQ    = 7'd1,
    F7_RETIRQ  = 7'd2,
    F7_MASKIRQ = 7'd3,
    F7_WAITIRQ = 7'd4,
    F7_TIMER   = 7'd5
  } ci_op_e;

  typedef struct packed {
    logic       getq;
    logic       setq;
    logic       retirq;
    logic       maskirq;
    logic       waitirq;
    logic       timer;
    logic [4:0] rd;
  } ci_dec_t;

  localparam int EXC_INSTR_BIT = 1;
  localparam int EXC_ALIGN_BIT = 2;
endpackage

// File: rtl/irq_shadow_decode.sv
module irq_shadow_decode
  import irq_shadow_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  output ci_dec_t     dec_o
);
  logic   hit;
  ci_op_e op;

  assign hit = valid_i && (instr_i[6:0] == CUSTOM0_OPC);
  assign op  = ci_op_e'(instr_i[31:25]);

  always_comb begin
    dec_o         = '0;
    dec_o.rd      = instr_i[11:7];
    dec_o.getq    = hit && (op == F7_GETQ);
    dec_o.setq    = hit && (op == F7_SETQ);
    dec_o.retirq  = hit && (op == F7_RETIRQ);
    dec_o.maskirq = hit && (op == F7_MASKIRQ);
    dec_o.waitirq = hit && (op == F7_WAITIRQ);
    dec_o.timer   = hit && (op == F7_TIMER);
  end
endmodule

// File: rtl/irq_shadow_edge.sv
module irq_shadow_edge #(
  parameter int NUM_IRQ = 32,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] lines_i,
  output logic [NUM_IRQ-1:0] raw_o,
  output logic [NUM_IRQ-1:0] rise_o,
  output logic [NUM_IRQ-1:0] drop_o
);
  logic [NUM_IRQ-1:0] raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= lines_i;
  end

  assign raw_o  = raw_q;
  assign rise_o = lines_i & ~raw_q;

  generate
    if (LATCHED) begin : g_latched
      assign drop_o = '0;
    end else begin : g_level
      assign drop_o = raw_q & ~lines_i;
    end
  endgenerate
endmodule

// File: rtl/irq_shadow_qbank.sv
module irq_shadow_qbank #(
  parameter int XLEN  = 32,
  parameter int NUM_Q = 4,
  localparam int QW   = $clog2(NUM_Q)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            entry_we_i,
  input  logic [XLEN-1:0] entry_pc_i,
  input  logic [XLEN-1:0] entry_set_i,
  input  logic            wr_en_i,
  input  logic [QW-1:0]   wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [QW-1:0]   rd_idx_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic [XLEN-1:0] q0_o
);
  logic [XLEN-1:0] q_q [NUM_Q];

  generate
    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
      logic            en;
      logic [XLEN-1:0] d;
      always_comb begin
        en = wr_en_i && (wr_idx_i == QW'(i));
        d  = wr_data_i;
        if (entry_we_i && i == 0) begin
          en = 1'b1;
          d  = entry_pc_i;
        end else if (entry_we_i && i == 1) begin
          en = 1'b1;
          d  = entry_set_i;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_q[i] <= '0;
        else if (en) q_q[i] <= d;
      end
    end
  endgenerate

  assign rd_data_o = q_q[rd_idx_i];
  assign q0_o      = q_q[0];
endmodule

// File: rtl/irq_shadow_ctrl.sv
module irq_shadow_ctrl
  import irq_shadow_pkg::*;
#(
  parameter int          NUM_IRQ = 32,
  parameter int          XLEN    = 32,
  parameter int          NUM_Q   = 4,
  parameter bit          LATCHED = 1'b1,
  parameter logic [31:0] VECTOR  = 32'h0000_0010
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_lines_i,
  input  logic               exc_instr_i,
  input  logic               exc_align_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               ci_valid_i,
  input  logic [31:0]        ci_instr_i,
  input  logic [XLEN-1:0]    ci_rs1_i,
  input  logic [XLEN-1:0]    tmr_count_i,
  output logic               rf_we_o,
  output logic [4:0]         rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic               redir_valid_o,
  output logic [XLEN-1:0]    redir_pc_o,
  output logic               wfi_req_o,
  output logic               halt_o,
  output logic               tmr_load_o,
  output logic [XLEN-1:0]    tmr_value_o
);
  localparam int QW = $clog2(NUM_Q);
  localparam logic [NUM_IRQ-1:0] EXC_BITS =
    (NUM_IRQ'(1) << EXC_INSTR_BIT) | (NUM_IRQ'(1) << EXC_ALIGN_BIT);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // state
  logic [NUM_IRQ-1:0] pend_q, pend_d;
  logic [NUM_IRQ-1:0] mask_q;
  logic               masked_q, masked_d;
  logic               wfi_q, wfi_d;
  logic               halt_q, halt_d;
  logic               rf_we_q, rf_we_d;
  logic [4:0]         rf_waddr_q;
  logic [XLEN-1:0]    rf_wdata_q, rf_wdata_d;
  logic               redir_q, redir_d;
  logic [XLEN-1:0]    redir_pc_q, redir_pc_d;
  logic               tload_q, tload_d;
  logic [XLEN-1:0]    tvalue_q;

  // submodules
  logic [NUM_IRQ-1:0] raw, rise, drop;
  ci_dec_t            dec;
  logic [XLEN-1:0]    q_rd, q0;

  irq_shadow_edge #(.NUM_IRQ(NUM_IRQ), .LATCHED(LATCHED)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .lines_i(irq_lines_i),
    .raw_o(raw), .rise_o(rise), .drop_o(drop)
  );

  irq_shadow_decode u_dec (
    .valid_i(ci_valid_i), .instr_i(ci_instr_i), .dec_o(dec)
  );

  // interrupt evaluation
  logic [NUM_IRQ-1:0] serv, exc_pend, exc_set;
  logic               fault, take, act, act_q_wr;

  always_comb begin
    serv     = masked_q ? '0 : (pend_q & ~mask_q);
    exc_pend = pend_q & EXC_BITS;
    fault    = (exc_pend != '0) && (masked_q || ((exc_pend & mask_q) != '0));
    take     = (serv != '0) && !fault && !halt_q;
    act      = !take && !halt_q;
    act_q_wr = act && dec.setq;
    exc_set  = '0;
    exc_set[EXC_INSTR_BIT] = exc_instr_i;
    exc_set[EXC_ALIGN_BIT] = exc_align_i;
  end

  irq_shadow_qbank #(.XLEN(XLEN), .NUM_Q(NUM_Q)) u_q (
    .clk(clk), .rst_n(rst_sync_n),
    .entry_we_i(take), .entry_pc_i(pc_i), .entry_set_i(XLEN'(serv)),
    .wr_en_i(act_q_wr), .wr_idx_i(ci_instr_i[7 +: QW]), .wr_data_i(ci_rs1_i),
    .rd_idx_i(ci_instr_i[15 +: QW]), .rd_data_o(q_rd), .q0_o(q0)
  );

  // next state
  always_comb begin
    pend_d = pend_q;
    if (take) pend_d = pend_d & ~serv;
    if (act && dec.retirq) pend_d = pend_d | raw;
    pend_d = (pend_d | rise | exc_set) & ~drop;

    masked_d = masked_q;
    if (take)                   masked_d = 1'b1;
    else if (act && dec.retirq) masked_d = 1'b0;

    wfi_d = wfi_q;
    if (take)                    wfi_d = 1'b0;
    else if (act && dec.waitirq) wfi_d = 1'b1;

    halt_d = halt_q | fault;

    rf_we_d = act && (dec.getq || dec.maskirq || dec.timer) && (dec.rd != 5'd0);
    if (dec.maskirq)    rf_wdata_d = XLEN'(mask_q);
    else if (dec.timer) rf_wdata_d = tmr_count_i;
    else                rf_wdata_d = q_rd;

    redir_d    = take || (act && dec.retirq);
    redir_pc_d = take ? XLEN'(VECTOR) : q0;
    tload_d    = act && dec.timer;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q   <= '0;
      masked_q <= 1'b0;
      wfi_q    <= 1'b0;
      halt_q   <= 1'b0;
      rf_we_q  <= 1'b0;
      redir_q  <= 1'b0;
      tload_q  <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      masked_q <= masked_d;
      wfi_q    <= wfi_d;
      halt_q   <= halt_d;
      rf_we_q  <= rf_we_d;
      redir_q  <= redir_d;
      tload_q  <= tload_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)              mask_q <= '1;
    else if (act && dec.maskirq)  mask_q <= ci_rs1_i[NUM_IRQ-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rf_waddr_q <= '0;
      rf_wdata_q <= '0;
    end else if (rf_we_d) begin
      rf_waddr_q <= dec.rd;
      rf_wdata_q <= rf_wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  redir_pc_q <= '0;
    else if (redir_d) redir_pc_q <= redir_pc_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  tvalue_q <= '0;
    else if (tload_d) tvalue_q <= ci_rs1_i;
  end

  assign rf_we_o       = rf_we_q;
  assign rf_waddr_o    = rf_waddr_q;
  assign rf_wdata_o    = rf_wdata_q;
  assign redir_valid_o = redir_q;
  assign redir_pc_o    = redir_pc_q;
  assign wfi_req_o     = wfi_q;
  assign halt_o        = halt_q;
  assign tmr_load_o    = tload_q;
  assign tmr_value_o   = tvalue_q;
endmodule

// File: rtl/irq_shadow_ctrl_chk.sv
module irq_shadow_ctrl_chk #(
  parameter int          XLEN   = 32,
  parameter logic [31:0] VECTOR = 32'h0000_0010
) (
  input logic            clk,
  input logic            rst_n,
  input logic            masked_q,
  input logic            ci_valid_i,
  input logic [31:0]     ci_instr_i,
  input logic            rf_we_o,
  input logic [4:0]      rf_waddr_o,
  input logic            redir_valid_o,
  input logic [XLEN-1:0] redir_pc_o,
  input logic            wfi_req_o,
  input logic            halt_o
);
  logic ret_issue;
  assign ret_issue = ci_valid_i && (ci_instr_i[6:0] == 7'b0001011) &&
                     (ci_instr_i[31:25] == 7'd2);

  assert_entry_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(masked_q) |-> (redir_valid_o && redir_pc_o == XLEN'(VECTOR)));

  assert_no_nested_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_q && !ret_issue) |=> !redir_valid_o);

  assert_rd_zero_never_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o != 5'd0));

  assert_wait_ends_at_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wfi_req_o) |-> redir_valid_o);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);

  assert_halt_no_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> !redir_valid_o);
endmodule

bind irq_shadow_ctrl irq_shadow_ctrl_chk #(.XLEN(XLEN), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .masked_q(masked_q),
  .ci_valid_i(ci_valid_i), .ci_instr_i(ci_instr_i),
  .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
  .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
  .wfi_req_o(wfi_req_o), .halt_o(halt_o)
);

// File: tb/irq_shadow_ctrl_test.sv
module irq_shadow_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [31:0] irq_lines;
  logic        exc_instr, exc_align;
  logic [31:0] pc;
  logic        ci_valid;
  logic [31:0] ci_instr, ci_rs1, tmr_count;

  logic        rf_we, redir, wfi, halt, tload;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata, redir_pc, tvalue;
  logic        rf_we2, redir2, wfi2, halt2, tload2;
  logic [4:0]  rf_waddr2;
  logic [31:0] rf_wdata2, redir_pc2, tvalue2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_shadow_ctrl uut (
    .clk(clk), .rst_ni(rst_ni), .irq_lines_i(irq_lines),
    .exc_instr_i(exc_instr), .exc_align_i(exc_align), .pc_i(pc),
    .ci_valid_i(ci_valid), .ci_instr_i(ci_instr), .ci_rs1_i(ci_rs1),
    .tmr_count_i(tmr_count), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr),
    .rf_wdata_o(rf_wdata), .redir_valid_o(redir), .redir_pc_o(redir_pc),
    .wfi_req_o(wfi), .halt_o(halt), .tmr_load_o(tload), .tmr_value_o(tvalue)
  );

  irq_shadow_ctrl #(.LATCHED(1'b0)) uut_lvl (
    .clk(clk), .rst_ni(rst_ni), .irq_lines_i(irq_lines),
    .exc_instr_i(exc_instr), .exc_align_i(exc_align), .pc_i(pc),
    .ci_valid_i(ci_valid), .ci_instr_i(ci_instr), .ci_rs1_i(ci_rs1),
    .tmr_count_i(tmr_count), .rf_we_o(rf_we2), .rf_waddr_o(rf_waddr2),
    .rf_wdata_o(rf_wdata2), .redir_valid_o(redir2), .redir_pc_o(redir_pc2),
    .wfi_req_o(wfi2), .halt_o(halt2), .tmr_load_o(tload2), .tmr_value_o(tvalue2)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive one custom instruction for one cycle; returns after its edge
  task automatic exec(input logic [6:0] f7, input logic [4:0] rd,
                      input logic [4:0] rs1f, input logic [31:0] val);
    ci_valid = 1'b1;
    ci_instr = {f7, 5'd0, rs1f, 3'd0, rd, 7'b0001011};
    ci_rs1   = val;
    @(negedge clk);
    ci_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rf_we", 32'(rf_we), 0);
    chk("R1 redirect", 32'(redir), 0);
    chk("R1 wfi", 32'(wfi), 0);
    chk("R1 halt", 32'(halt), 0);
    chk("R1 tmr_load", 32'(tload), 0);
  endtask

  task automatic t_mask();
    exec(7'd3, 5'd5, 5'd2, ~32'h0000_0090);
    chk("R1 R2 maskirq write", 32'(rf_we), 1);
    chk("R2 maskirq rd", 32'(rf_waddr), 5);
    chk("R1 R2 old mask", rf_wdata, 32'hFFFF_FFFF);
    exec(7'd3, 5'd0, 5'd2, ~32'h0000_0090);
    chk("R2 rd x0 no write", 32'(rf_we), 0);
    exec(7'd3, 5'd4, 5'd2, ~32'h0000_0090);
    chk("R2 readback", rf_wdata, ~32'h0000_0090);
  endtask

  task automatic t_entry_return();
    pc = 32'h1234;
    irq_lines[4] = 1'b1;
    @(negedge clk);
    chk("R3 R4 no redirect yet", 32'(redir), 0);
    @(negedge clk);
    chk("R4 entry redirect", 32'(redir), 1);
    chk("R4 entry vector", redir_pc, 32'h10);
    exec(7'd0, 5'd6, 5'd1, 0);
    chk("R4 R7 Q1 set", rf_wdata, 32'h10);
    exec(7'd0, 5'd7, 5'd0, 0);
    chk("R4 R7 Q0 pc", rf_wdata, 32'h1234);
    irq_lines[7] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 masked no entry", 32'(redir), 0);
    end
    pc = 32'h2000;
    exec(7'd2, 5'd0, 5'd0, 0);
    chk("R6 return redirect", 32'(redir), 1);
    chk("R6 return target", redir_pc, 32'h1234);
    @(negedge clk);
    chk("R6 reentry redirect", 32'(redir), 1);
    chk("R6 reentry vector", redir_pc, 32'h10);
    irq_lines[4] = 1'b0;
    irq_lines[7] = 1'b0;
    exec(7'd0, 5'd8, 5'd1, 0);
    chk("R6 Q1 both lines", rf_wdata, 32'h90);
    exec(7'd2, 5'd0, 5'd0, 0);
    chk("R6 second return", redir_pc, 32'h2000);
    @(negedge clk);
    chk("R6 no spurious entry", 32'(redir), 0);
  endtask

  task automatic t_shadow();
    exec(7'd1, 5'd2, 5'd9, 32'hCAFE_0001);
    chk("R7 setq no rf write", 32'(rf_we), 0);
    exec(7'd0, 5'd9, 5'd2, 0);
    chk("R7 getq data", rf_wdata, 32'hCAFE_0001);
    chk("R7 getq rd", 32'(rf_waddr), 9);
    exec(7'd0, 5'd0, 5'd2, 0);
    chk("R7 getq x0", 32'(rf_we), 0);
  endtask

  task automatic t_wait();
    exec(7'd4, 5'd0, 5'd0, 0);
    chk("R8 wait raised", 32'(wfi), 1);
    idle(3);
    chk("R8 wait held", 32'(wfi), 1);
    irq_lines[7] = 1'b1;
    @(negedge clk);
    chk("R8 wait before entry", 32'(wfi), 1);
    @(negedge clk);
    chk("R8 wait cleared", 32'(wfi), 0);
    chk("R8 entry redirect", 32'(redir), 1);
    irq_lines[7] = 1'b0;
    @(negedge clk);
    exec(7'd2, 5'd0, 5'd0, 0);
    @(negedge clk);
  endtask

  task automatic t_timer();
    tmr_count = 32'h55;
    exec(7'd5, 5'd3, 5'd1, 32'h100);
    chk("R9 timer load", 32'(tload), 1);
    chk("R9 timer value", tvalue, 32'h100);
    chk("R9 old count", rf_wdata, 32'h55);
    chk("R9 rd", 32'(rf_waddr), 3);
    @(negedge clk);
    chk("R9 load pulse", 32'(tload), 0);
  endtask

  task automatic t_unknown();
    exec(7'd6, 5'd5, 5'd1, 32'h0);
    chk("R12 funct7 6 ignored", 32'(rf_we), 0);
    chk("R12 funct7 6 no redirect", 32'(redir), 0);
    ci_valid = 1'b1;
    ci_instr = {7'd3, 5'd0, 5'd1, 3'd0, 5'd5, 7'b0101011};
    ci_rs1   = 32'h0;
    @(negedge clk);
    ci_valid = 1'b0;
    chk("R12 other opcode ignored", 32'(rf_we), 0);
    exec(7'd3, 5'd5, 5'd1, ~32'h0000_0090);
    chk("R12 mask unchanged", rf_wdata, ~32'h0000_0090);
  endtask

  task automatic t_latch_modes();
    irq_lines[9] = 1'b1;
    @(negedge clk);
    irq_lines[9] = 1'b0;
    idle(2);
    exec(7'd3, 5'd0, 5'd1, ~32'h0000_0290);
    @(negedge clk);
    chk("R3 latched enters", 32'(redir), 1);
    chk("R3 level drops", 32'(redir2), 0);
    exec(7'd0, 5'd8, 5'd1, 0);
    chk("R3 latched Q1", rf_wdata, 32'h200);
    exec(7'd2, 5'd0, 5'd0, 0);
    @(negedge clk);
  endtask

  task automatic t_exceptions();
    exec(7'd3, 5'd0, 5'd1, ~32'h0000_0294);
    exc_align = 1'b1;
    @(negedge clk);
    exc_align = 1'b0;
    @(negedge clk);
    chk("R11 exception entry", 32'(redir), 1);
    chk("R11 no halt", 32'(halt), 0);
    exec(7'd0, 5'd8, 5'd1, 0);
    chk("R11 Q1 bit2", rf_wdata, 32'h4);
    exc_align = 1'b1;
    @(negedge clk);
    exc_align = 1'b0;
    chk("R10 halt not yet", 32'(halt), 0);
    @(negedge clk);
    chk("R10 halt in handler", 32'(halt), 1);
    chk("R10 no redirect", 32'(redir), 0);
    exec(7'd2, 5'd0, 5'd0, 0);
    chk("R10 return ignored", 32'(redir), 0);
    exec(7'd3, 5'd5, 5'd1, 0);
    chk("R10 maskirq ignored", 32'(rf_we), 0);
    t_reset();
    exc_instr = 1'b1;
    @(negedge clk);
    exc_instr = 1'b0;
    @(negedge clk);
    chk("R10 R11 halt disabled source", 32'(halt), 1);
    chk("R10 disabled no entry", 32'(redir), 0);
  endtask

  initial begin
    rst_ni    = 1'b0;
    irq_lines = '0;
    exc_instr = 1'b0;
    exc_align = 1'b0;
    pc        = '0;
    ci_valid  = 1'b0;
    ci_instr  = '0;
    ci_rs1    = '0;
    tmr_count = '0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_entry_return();
    t_shadow();
    t_wait();
    t_timer();
    t_unknown();
    t_latch_modes();
    t_exceptions();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule